// File: doc/BRIEF.md
# Miss Acknowledgement Tracker

This block follows one outstanding coherence miss that was broadcast to every cache in the system. When the miss is issued, the tracker loads the number of replies it expects: one from each other cache plus one from memory, which equals the total cache count. Each reply that arrives carries an acknowledgement weight, and the tracker subtracts that weight from the count. A shared reply marks that another cache kept a copy. Two single-step inputs adjust the count while the miss is in flight. The decrement is used when a store upgrade starts from a locally owned line, because the local copy already supplies the data. The increment is used when that ownership is lost to a foreign exclusive request before the upgrade completes.

When an update brings the count to zero, the tracker emits one completion pulse. A flag beside the pulse tells whether any sharer replied, so the completion reads as "all acks, sharers seen" or "all acks, no sharers". The tracker also holds the source of the most recent reply and the timestamp of the first reply.

The controller has three states. `TRK_IDLE` waits for an issue. `TRK_WAIT` accepts replies and adjustments. `TRK_FIRE` lasts one cycle and drives the completion pulse. The transitions are:
- idle-to-wait, on an accepted issue;
- wait-to-fire, on an update that leaves the count at zero;
- fire-to-idle, which is unconditional.

Top module: `miss_ack_tracker`

## Requirements
- R1: After reset the tracker is idle: `busy_o`=0, `done_o`=0, `pending_o`=0, `last_src_o`=0, `first_time_o`=0.
- R2: An `issue_i` pulse in idle loads `pending_o` with NUM_CACHES, raises `busy_o` in the next cycle and clears the sharer record.
- R3: While waiting, a reply (`rsp_valid_i`) subtracts `rsp_acks_i` from the count. The ack weight must be at least one, and no update may take the count below zero.
- R4: While waiting, `dec_i` lowers the count by one and `inc_i` raises it by one. Both pulses, and a reply, may arrive in the same cycle and their effects add.
- R5: When an update leaves the count at zero, `done_o` is high for exactly the one cycle after that update, and the tracker then returns to idle. Exactly one completion occurs per miss, whichever input caused the zero.
- R6: `done_sharers_o` is 1 with `done_o` if any reply since the issue had `rsp_shared_i`=1, including the final reply, and is 0 otherwise.
- R7: `last_src_o` holds `rsp_src_i` of the most recent accepted reply.
- R8: `first_time_o` captures `now_i` at the first accepted reply after an issue and does not change on later replies of that miss.
- R9: Issue pulses while busy are ignored, and replies and adjustments while not waiting are ignored. The count, the recorded source and the pulse outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Start tracking a new miss |
| rsp_valid_i | input | 1 | Reply received this cycle |
| rsp_acks_i | input | CNT_W | Ack weight carried by the reply |
| rsp_shared_i | input | 1 | Replier kept a shared copy |
| rsp_src_i | input | SRC_W | Identifier of the replier |
| now_i | input | TIME_W | Current timestamp |
| inc_i | input | 1 | Raise the count by one (ownership lost) |
| dec_i | input | 1 | Lower the count by one (local copy supplies data) |
| busy_o | output | 1 | A miss is being tracked |
| pending_o | output | CNT_W | Replies still outstanding |
| done_o | output | 1 | One-cycle completion pulse |
| done_sharers_o | output | 1 | Completion kind: 1 = sharers seen |
| last_src_o | output | SRC_W | Source of the latest reply |
| first_time_o | output | TIME_W | Timestamp of the first reply |

## Verification
Two cases are hard to reach from the ports. The first is a completion caused by a single-step adjustment rather than by a reply. The bench reaches it by walking the count down with decrements, an increment, and a combined increment-plus-decrement cycle, then closing the miss with a final `dec_i`. The second is a shared reply that is also the final one. That reply must both set the sharer kind and fire the completion in the same update. The bench also sends replies during the fire cycle and while idle, then confirms that no second pulse appears and the count stays put.

// File: rtl/miss_ack_pkg.sv
package miss_ack_pkg;
    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_WAIT = 2'd1,
        TRK_FIRE = 2'd2
    } trk_state_t;
endpackage

// File: rtl/miss_ack_count.sv
module miss_ack_count #(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             upd_i,
    input  logic             rsp_i,
    input  logic [CNT_W-1:0] acks_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_next_o
);
    localparam int EXT_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(NUM_CACHES);

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] ext_sum;
    logic [EXT_W-1:0] sub_amt;

    always_comb begin
        sub_amt = rsp_i ? {1'b0, acks_i} : '0;
        ext_sum = {1'b0, cnt_q} + EXT_W'(inc_i) - sub_amt - EXT_W'(dec_i);
    end

    assign zero_next_o = (ext_sum[CNT_W-1:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= PRELOAD;
        else if (upd_i)
            cnt_q <= ext_sum[CNT_W-1:0];
    end

    assign cnt_o = cnt_q;

    // The combined update must never borrow past zero.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |-> ({1'b0, cnt_q} + EXT_W'(inc_i)) >= (sub_amt + EXT_W'(dec_i)));

    assert_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == PRELOAD);
endmodule

// File: rtl/miss_ack_record.sv
module miss_ack_record #(
    parameter int SRC_W  = 3,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              rsp_i,
    input  logic              shared_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [TIME_W-1:0] now_i,
    output logic              sharers_o,
    output logic              sharers_next_o,
    output logic [SRC_W-1:0]  last_src_o,
    output logic [TIME_W-1:0] first_time_o
);
    logic              sharers_q;
    logic              got_first_q;
    logic [SRC_W-1:0]  last_src_q;
    logic [TIME_W-1:0] first_time_q;

    assign sharers_next_o = sharers_q | (rsp_i & shared_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sharers_q    <= 1'b0;
            got_first_q  <= 1'b0;
            last_src_q   <= '0;
            first_time_q <= '0;
        end else if (clear_i) begin
            sharers_q   <= 1'b0;
            got_first_q <= 1'b0;
        end else if (rsp_i) begin
            sharers_q  <= sharers_next_o;
            last_src_q <= src_i;
            if (!got_first_q) begin
                got_first_q  <= 1'b1;
                first_time_q <= now_i;
            end
        end
    end

    assign sharers_o    = sharers_q;
    assign last_src_o   = last_src_q;
    assign first_time_o = first_time_q;

    assert_first_time_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (got_first_q && !clear_i) |=> $stable(first_time_q));

    assert_sharer_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sharers_q && !clear_i) |=> sharers_q);

    assert_src_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_i |=> last_src_q == $past(src_i));
endmodule

// File: rtl/miss_ack_tracker.sv
module miss_ack_tracker
    import miss_ack_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int SRC_W      = 3,
    parameter int TIME_W     = 16,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              rsp_valid_i,
    input  logic [CNT_W-1:0]  rsp_acks_i,
    input  logic              rsp_shared_i,
    input  logic [SRC_W-1:0]  rsp_src_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic              busy_o,
    output logic [CNT_W-1:0]  pending_o,
    output logic              done_o,
    output logic              done_sharers_o,
    output logic [SRC_W-1:0]  last_src_o,
    output logic [TIME_W-1:0] first_time_o
);
    trk_state_t state_q, state_d;
    logic       take_issue;
    logic       take_rsp;
    logic       take_upd;
    logic       zero_next;
    logic       sharers_q;
    logic       sharers_next;

    assign take_issue = (state_q == TRK_IDLE) && issue_i;
    assign take_rsp   = (state_q == TRK_WAIT) && rsp_valid_i;
    assign take_upd   = (state_q == TRK_WAIT) && (rsp_valid_i || inc_i || dec_i);

    miss_ack_count #(
        .NUM_CACHES (NUM_CACHES),
        .CNT_W      (CNT_W)
    ) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take_issue),
        .upd_i       (take_upd),
        .rsp_i       (take_rsp),
        .acks_i      (rsp_acks_i),
        .inc_i       (inc_i),
        .dec_i       (dec_i),
        .cnt_o       (pending_o),
        .zero_next_o (zero_next)
    );

    miss_ack_record #(
        .SRC_W  (SRC_W),
        .TIME_W (TIME_W)
    ) record_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (take_issue),
        .rsp_i          (take_rsp),
        .shared_i       (rsp_shared_i),
        .src_i          (rsp_src_i),
        .now_i          (now_i),
        .sharers_o      (sharers_q),
        .sharers_next_o (sharers_next),
        .last_src_o     (last_src_o),
        .first_time_o   (first_time_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (take_issue) state_d = TRK_WAIT;
            TRK_WAIT: if (take_upd && zero_next) state_d = TRK_FIRE;
            TRK_FIRE: state_d = TRK_IDLE;
            default:  state_d = TRK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy_o         = (state_q != TRK_IDLE);
        done_o         = (state_q == TRK_FIRE);
        done_sharers_o = (state_q == TRK_FIRE) && sharers_q;
    end

    assert_ack_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && rsp_valid_i) |-> rsp_acks_i != '0);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    assert_done_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pending_o == '0);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !issue_i) |=> $stable(pending_o) && !done_o);

    assert_issue_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && issue_i) |=> busy_o && !done_o);

    assert_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_upd && zero_next) |=> done_sharers_o == $past(sharers_next));
endmodule

// File: tb/miss_ack_tracker_tb_top.sv
`timescale 1ns/1ps
module miss_ack_tracker_tb_top;
    localparam int NC  = 4;
    localparam int SW  = 3;
    localparam int TW  = 16;
    localparam int CW  = $clog2(NC + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic          rsp_valid_i = 1'b0;
    logic [CW-1:0] rsp_acks_i = '0;
    logic          rsp_shared_i = 1'b0;
    logic [SW-1:0] rsp_src_i = '0;
    logic [TW-1:0] now_i = '0;
    logic          inc_i = 1'b0;
    logic          dec_i = 1'b0;
    logic          busy_o, done_o, done_sharers_o;
    logic [CW-1:0] pending_o;
    logic [SW-1:0] last_src_o;
    logic [TW-1:0] first_time_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    miss_ack_tracker #(.NUM_CACHES(NC), .SRC_W(SW), .TIME_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rsp_valid_i(rsp_valid_i),
        .rsp_acks_i(rsp_acks_i), .rsp_shared_i(rsp_shared_i), .rsp_src_i(rsp_src_i),
        .now_i(now_i), .inc_i(inc_i), .dec_i(dec_i), .busy_o(busy_o),
        .pending_o(pending_o), .done_o(done_o), .done_sharers_o(done_sharers_o),
        .last_src_o(last_src_o), .first_time_o(first_time_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge, return at the next negedge.
    task automatic step(input bit iss, input bit rv, input int acks, input bit sh,
                        input int src, input bit inc, input bit dec);
        issue_i = iss; rsp_valid_i = rv; rsp_acks_i = CW'(acks);
        rsp_shared_i = sh; rsp_src_i = SW'(src); inc_i = inc; dec_i = dec;
        @(negedge clk);
        issue_i = 0; rsp_valid_i = 0; rsp_acks_i = '0; rsp_shared_i = 0;
        inc_i = 0; dec_i = 0;
    endtask

    task automatic idle_cycle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "pending", pending_o, 0);
        chk("R1", "last_src", last_src_o, 0);
        chk("R1", "first_time", first_time_o, 0);
    endtask

    task automatic t_sharers();
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R2", "pending after issue", pending_o, NC);
        chk("R2", "busy after issue", busy_o, 1);
        now_i = 16'd50;
        step(0, 1, 2, 1, 3, 0, 0);
        chk("R3", "pending after 2-ack shared reply", pending_o, 2);
        chk("R5", "no early done", done_o, 0);
        now_i = 16'd60;
        step(0, 1, 2, 0, 4, 0, 0);
        chk("R5", "done on zero", done_o, 1);
        chk("R6", "sharers kind", done_sharers_o, 1);
        chk("R8", "first time", first_time_o, 50);
        idle_cycle();
        chk("R5", "done drops", done_o, 0);
        chk("R5", "idle after fire", busy_o, 0);
    endtask

    task automatic t_no_sharers();
        step(1, 0, 0, 0, 0, 0, 0);
        now_i = 16'd100;
        step(0, 1, 1, 0, 2, 0, 0);
        chk("R3", "pending after 1-ack reply", pending_o, 3);
        chk("R7", "last src", last_src_o, 2);
        chk("R8", "first time after issue", first_time_o, 100);
        now_i = 16'd200;
        step(0, 1, 3, 0, 5, 0, 0);
        chk("R5", "done", done_o, 1);
        chk("R6", "no-sharers kind (flag cleared on issue)", done_sharers_o, 0);
        chk("R7", "last src updated", last_src_o, 5);
        chk("R8", "first time held", first_time_o, 100);
        idle_cycle();
    endtask

    task automatic t_final_shared();
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 3, 0, 1, 0, 0);
        chk("R3", "pending", pending_o, 1);
        step(0, 1, 1, 1, 6, 0, 0);
        chk("R5", "done", done_o, 1);
        chk("R6", "shared on final reply", done_sharers_o, 1);
        idle_cycle();
    endtask

    task automatic t_adjust();
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R4", "dec", pending_o, 3);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R4", "inc", pending_o, 4);
        step(0, 0, 0, 0, 0, 1, 1);
        chk("R4", "inc+dec", pending_o, 4);
        step(0, 1, 2, 0, 7, 1, 0);
        chk("R4", "reply+inc", pending_o, 3);
        step(0, 1, 2, 0, 7, 0, 0);
        chk("R4", "reply", pending_o, 1);
        chk("R5", "not done at one", done_o, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R5", "done via dec", done_o, 1);
        chk("R6", "kind", done_sharers_o, 0);
        idle_cycle();
        chk("R5", "single pulse", done_o, 0);
    endtask

    task automatic t_ignored();
        step(0, 1, 2, 1, 1, 1, 0);
        chk("R9", "idle reply pending", pending_o, 0);
        chk("R9", "idle reply busy", busy_o, 0);
        chk("R9", "idle reply src", last_src_o, 7);
        chk("R9", "idle reply done", done_o, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 3, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R9", "issue while busy", pending_o, 3);
        step(0, 1, 3, 0, 4, 0, 0);
        chk("R5", "done", done_o, 1);
        step(0, 1, 1, 1, 2, 0, 1);
        chk("R9", "reply in fire ignored pending", pending_o, 0);
        chk("R9", "reply in fire ignored src", last_src_o, 4);
        chk("R5", "no second done", done_o, 0);
        idle_cycle();
        chk("R5", "still quiet", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sharers();
        t_no_sharers();
        t_final_shared();
        t_adjust();
        t_ignored();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule